// File: doc/BRIEF.md
# Framed serial transmitter with sync-error detection

This block is the transmit half of a frame-synchronized serial port. Software or a DMA engine writes a parallel word into a holding buffer. The word moves into a shift register and is sent most-significant bit first on a single data pin, one bit per period of an externally supplied bit clock. Each word goes out in response to a frame-sync pulse, after a data delay of zero, one or two bit-clock periods.

The block runs on a fast system clock. The bit clock and the frame sync arrive as inputs that are already synchronous to it. The block finds their edges internally. Data changes after a rising bit-clock edge, and the sync is sampled at a falling edge.

Two faults are detected and latched:
- **Underflow.** A frame starts with no word ready. The pin then carries zeros for the whole frame.
- **Sync error.** A sync pulse arrives while the current frame still has more bits to send than the delay can absorb. The shifter ignores that pulse, so the frame in progress carries on undisturbed.

The flags drive an active-low interrupt through per-flag enables and clear by write-one-to-clear. A separate compatibility copy of the sync-error flag clears only on reset or on an explicit clear strobe. One interrupt-mode setting adds a request pulse on every sync error.

Top module: `frame_tx_port`

## Requirements
- R1: After reset, `dout`=0, `buf_empty`=1, `undf_flag`=0, `serr_flag`=0, `serr_legacy`=0, `irq_n`=1 and `tx_int`=0.
- R2: A word written into an empty buffer while no frame is shifting moves into the shift register within two system clocks, without any sync pulse, and `buf_empty` returns to 1.
- R3: A buffer write clears `buf_empty` on the next clock. While the shift register still holds an unsent word, `buf_empty` stays 0. The buffered word moves into the shift register after the last bit of the current frame is driven, which sets `buf_empty` to 1.
- R4: A frame sends its W bits most-significant first. Each bit is driven after a rising `bclk` edge and held until the next one. A sync is a 0-to-1 change of `fsync` between two consecutive falling `bclk` edges.
- R5: With `dly_sel`=d (0, 1 or 2), the first bit of a frame is driven on the (d+1)-th rising `bclk` edge after the falling edge that sampled the sync. Consecutive frames with no idle bit are therefore possible.
- R6: If a frame starts while the shift register holds no unsent word, the frame carries W zero bits and `undf_flag` sets.
- R7: A sync that is not accepted leaves the frame in progress unchanged, starts no frame and sets `serr_flag`.
- R8: A `clr_wr` pulse clears `undf_flag` when `clr_mask[0]`=1 and clears `serr_flag` when `clr_mask[1]`=1. A flag whose mask bit is 0 is unchanged. A new setting event wins over a clear in the same cycle.
- R9: `irq_n` is 0 exactly when (`undf_flag` and `ien_undf`) or (`serr_flag` and `ien_serr`).
- R10: `serr_legacy` sets together with `serr_flag`. It is not affected by `clr_wr` and clears only on a `leg_clr` pulse or on reset.
- R11: When `int_mode`=2'b11, `tx_int` pulses high for one clock on each sync error. For any other `int_mode` value it stays 0.
- R12: A sync is accepted only if no accepted sync is still waiting for its delay to run out, and the number of bits of the current frame not yet driven is at most d. Otherwise it is a sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous transmitter reset |
| bclk | input | 1 | Bit clock, synchronous to `clk`, each phase at least 2 clocks long |
| fsync | input | 1 | Frame sync, synchronous to `clk` |
| buf_wr | input | 1 | Write strobe for the transmit buffer |
| buf_din | input | W | Word to transmit |
| dly_sel | input | 2 | Data delay in bit periods (0, 1, 2; 3 acts as 2) |
| int_mode | input | 2 | Interrupt mode; 2'b11 enables `tx_int` on sync errors |
| ien_undf | input | 1 | Interrupt enable for underflow |
| ien_serr | input | 1 | Interrupt enable for sync error |
| clr_wr | input | 1 | Write-one-to-clear strobe for the status flags |
| clr_mask | input | 2 | Bit 0 clears underflow, bit 1 clears sync error |
| leg_clr | input | 1 | Clear strobe for the compatibility sync-error copy |
| dout | output | 1 | Serial data out |
| buf_empty | output | 1 | Transmit buffer holds no word |
| undf_flag | output | 1 | Underflow status |
| serr_flag | output | 1 | Sync-error status |
| serr_legacy | output | 1 | Compatibility copy of sync error |
| irq_n | output | 1 | Active-low interrupt |
| tx_int | output | 1 | One-clock transmit interrupt request |

## Verification
The assertions assume that:
- `bclk` and `fsync` are synchronous to `clk`, and each `bclk` phase spans several clocks, so rising and falling events never fall in the same or adjacent cycles.
- The buffer is written only while `buf_empty` is 1.
- `int_mode` does not change between a sync error and its request pulse.

The bench keeps within these assumptions:
- It generates every `bclk` period as four clocks high and four clocks low.
- It holds `fsync` for a whole bit period.
- It writes the buffer only after seeing `buf_empty` high.
- It changes `dly_sel` only at the start of the period that carries a sync, before that sync is sampled.

The random stream places each sync at or after the earliest legal point for the chosen delay. Only the directed cases put a sync inside the forbidden window.

// File: rtl/frame_tx_port.sv
module frame_tx_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         fsync,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_din,
  input  logic [1:0]   dly_sel,
  input  logic [1:0]   int_mode,
  input  logic         ien_undf,
  input  logic         ien_serr,
  input  logic         clr_wr,
  input  logic [1:0]   clr_mask,
  input  logic         leg_clr,
  output logic         dout,
  output logic         buf_empty,
  output logic         undf_flag,
  output logic         serr_flag,
  output logic         serr_legacy,
  output logic         irq_n,
  output logic         tx_int
);
  localparam int CW = $clog2(W + 1);

  logic          bclk_q, fs_q;
  logic [W-1:0]  xbuf, sr;
  logic          buf_full, sr_valid, pend;
  logic [CW-1:0] bits_left;
  logic [1:0]    pdly;

  wire       rise      = bclk & ~bclk_q;
  wire       fall      = ~bclk & bclk_q;
  wire       sync_evt  = fall & fsync & ~fs_q;
  wire [1:0] dsel      = (dly_sel == 2'd3) ? 2'd2 : dly_sel;
  wire       window_ok = ~pend & (bits_left <= CW'(dsel));
  wire       accept    = sync_evt & window_ok;
  wire       sync_bad  = sync_evt & ~window_ok;
  wire       start     = rise & pend & (pdly == 2'd0);
  wire       load      = ~sr_valid & buf_full & (bits_left == '0) & ~start;

  assign buf_empty = ~buf_full;
  assign irq_n     = ~((undf_flag & ien_undf) | (serr_flag & ien_serr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q      <= 1'b0;
      fs_q        <= 1'b0;
      xbuf        <= '0;
      sr          <= '0;
      buf_full    <= 1'b0;
      sr_valid    <= 1'b0;
      pend        <= 1'b0;
      pdly        <= 2'd0;
      bits_left   <= '0;
      dout        <= 1'b0;
      undf_flag   <= 1'b0;
      serr_flag   <= 1'b0;
      serr_legacy <= 1'b0;
      tx_int      <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (fall) fs_q <= fsync;

      if (buf_wr) begin
        xbuf     <= buf_din;
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end

      if (load) begin
        sr       <= xbuf;
        sr_valid <= 1'b1;
      end

      if (start) begin
        dout      <= sr_valid & sr[W-1];
        sr        <= sr_valid ? (sr << 1) : '0;
        sr_valid  <= 1'b0;
        bits_left <= CW'(W - 1);
        pend      <= 1'b0;
      end else if (rise) begin
        if (bits_left != '0) begin
          dout      <= sr[W-1];
          sr        <= sr << 1;
          bits_left <= bits_left - CW'(1);
        end
        if (pend) pdly <= pdly - 2'd1;
      end

      if (accept) begin
        pend <= 1'b1;
        pdly <= dsel;
      end

      undf_flag   <= (start & ~sr_valid) | (undf_flag & ~(clr_wr & clr_mask[0]));
      serr_flag   <= sync_bad | (serr_flag & ~(clr_wr & clr_mask[1]));
      serr_legacy <= sync_bad | (serr_legacy & ~leg_clr);
      tx_int      <= sync_bad & (int_mode == 2'b11);
    end
  end
endmodule

// File: rtl/frame_tx_port_chk.sv
module frame_tx_port_chk #(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rise,
  input logic                   pend,
  input logic [1:0]             pdly,
  input logic [$clog2(W+1)-1:0] bits_left,
  input logic                   buf_wr,
  input logic                   buf_empty,
  input logic                   dout,
  input logic                   undf_flag,
  input logic                   serr_flag,
  input logic                   serr_legacy,
  input logic                   irq_n,
  input logic                   tx_int
);
  localparam int CW = $clog2(W + 1);

  p_dout_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(dout));

  p_pend_fits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (bits_left <= CW'(pdly)));

  p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> !buf_empty);

  p_zero_on_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undf_flag) |-> !dout);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (undf_flag || serr_flag));

  p_legacy_with_serr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_flag) |-> serr_legacy);

  p_tx_int_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |-> (serr_flag && serr_legacy));

  p_tx_int_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |=> !tx_int);
endmodule

bind frame_tx_port frame_tx_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .pend(pend), .pdly(pdly),
  .bits_left(bits_left), .buf_wr(buf_wr), .buf_empty(buf_empty), .dout(dout),
  .undf_flag(undf_flag), .serr_flag(serr_flag), .serr_legacy(serr_legacy),
  .irq_n(irq_n), .tx_int(tx_int)
);

// File: tb/tb_frame_tx_port.sv
module tb_frame_tx_port;
  localparam int W  = 8;
  localparam int NF = 24;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic buf_wr = 1'b0, ien_undf = 1'b0, ien_serr = 1'b0;
  logic clr_wr = 1'b0, leg_clr = 1'b0;
  logic [W-1:0] buf_din = '0;
  logic [1:0] dly_sel = 2'd0, int_mode = 2'd0, clr_mask = 2'd0;
  logic dout, buf_empty, undf_flag, serr_flag, serr_legacy, irq_n, tx_int;

  frame_tx_port #(.W(W)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, ncyc = 0, qhead = 0, qn = 0, int_cnt = 0;
  logic bits [0:1023];
  logic [W-1:0] wq [0:NF-1];
  int sk [0:NF-1];
  int sd [0:NF-1];
  logic auto_wr = 1'b0;

  always @(posedge clk) if (tx_int) int_cnt <= int_cnt + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] grab(input int first);
    logic [W-1:0] v;
    for (int j = 0; j < W; j++) v[W-1-j] = bits[first + j];
    return v;
  endfunction

  function automatic logic [W-1:0] expect_word(input logic [W-1:0] w, input logic underflow);
    return underflow ? '0 : w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bclk = 0; fsync = 0; buf_wr = 0; clr_wr = 0; leg_clr = 0;
    ien_undf = 0; ien_serr = 0; int_mode = 0; dly_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; ncyc = 0; auto_wr = 0; qhead = 0; qn = 0; int_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic fs);
    @(negedge clk);
    bclk = 1; fsync = fs;
    if (auto_wr && buf_empty && qhead < qn) begin
      buf_wr = 1; buf_din = wq[qhead]; qhead++;
    end
    @(negedge clk);
    buf_wr = 0;
    repeat (3) @(negedge clk);
    bclk = 0; bits[ncyc] = dout; ncyc++;
    repeat (3) @(negedge clk);
  endtask

  task automatic write_word(input logic [W-1:0] w);
    @(negedge clk); buf_wr = 1; buf_din = w;
    @(negedge clk); buf_wr = 0;
    @(negedge clk);
  endtask

  task automatic clear_flags(input logic [1:0] m);
    @(negedge clk); clr_wr = 1; clr_mask = m;
    @(negedge clk); clr_wr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, d, g, s;
    logic [W-1:0] got;
    s = $urandom(32'd4242);

    // R1 reset state
    do_reset();
    chk(dout == 0, "R1 dout", dout, 0);
    chk(buf_empty == 1, "R1 buf_empty", buf_empty, 1);
    chk(undf_flag == 0 && serr_flag == 0, "R1 flags", {undf_flag, serr_flag}, 0);
    chk(serr_legacy == 0, "R1 legacy", serr_legacy, 0);
    chk(irq_n == 1 && tx_int == 0, "R1 irq", {irq_n, tx_int}, 2);

    // R2 immediate transfer, R3 buffer handling, R5 delays 1 and 0
    write_word(8'hA5);
    chk(buf_empty == 1, "R2 immediate transfer", buf_empty, 1);
    write_word(8'h3C);
    chk(buf_empty == 0, "R3 buffer held while shift register full", buf_empty, 0);
    dly_sel = 2'd1;
    k = ncyc; bit_cycle(1);
    repeat (W + 2) bit_cycle(0);
    got = grab(k + 2);
    chk(got == expect_word(8'hA5, 0), "R5 delay one word", got, 8'hA5);
    chk(buf_empty == 1, "R3 transfer after last bit", buf_empty, 1);
    dly_sel = 2'd0;
    k = ncyc; bit_cycle(1);
    repeat (W + 1) bit_cycle(0);
    got = grab(k + 1);
    chk(got == expect_word(8'h3C, 0), "R5 delay zero word", got, 8'h3C);
    chk(undf_flag == 0 && serr_flag == 0, "R4 clean frames", {undf_flag, serr_flag}, 0);

    // R4 R5 random legal stream
    do_reset();
    for (int f = 0; f < NF; f++) wq[f] = W'($urandom);
    qn = NF; auto_wr = 1;
    bit_cycle(0); bit_cycle(0);
    for (int f = 0; f < NF; f++) begin
      d = $urandom % 3; g = $urandom % 3;
      dly_sel = 2'(d);
      sk[f] = ncyc; sd[f] = d;
      bit_cycle(1);
      repeat (d + W + g - 1) bit_cycle(0);
    end
    repeat (W + 4) bit_cycle(0);
    for (int f = 0; f < NF; f++) begin
      got = grab(sk[f] + 1 + sd[f]);
      chk(got == expect_word(wq[f], 0), $sformatf("R4 R5 stream frame %0d delay %0d", f, sd[f]), got, wq[f]);
    end
    chk(undf_flag == 0 && serr_flag == 0, "R12 legal stream no errors", {undf_flag, serr_flag}, 0);

    // R6 underflow, R8 clear by mask, R9 interrupt
    do_reset();
    ien_undf = 1; dly_sel = 2'd0;
    k = ncyc; bit_cycle(1);
    repeat (W + 1) bit_cycle(0);
    got = grab(k + 1);
    chk(got == expect_word(8'hFF, 1), "R6 zeros on underflow", got, 0);
    chk(undf_flag == 1, "R6 underflow flag", undf_flag, 1);
    chk(irq_n == 0, "R9 irq on underflow", irq_n, 0);
    clear_flags(2'b10);
    chk(undf_flag == 1, "R8 other mask bit keeps underflow", undf_flag, 1);
    clear_flags(2'b01);
    chk(undf_flag == 0, "R8 underflow cleared", undf_flag, 0);
    chk(irq_n == 1, "R9 irq released", irq_n, 1);

    // R7 early sync ignored, R9 R10 R11 flag behaviour
    do_reset();
    int_mode = 2'b11; dly_sel = 2'd0;
    write_word(8'h96);
    k = ncyc; bit_cycle(1);
    repeat (3) bit_cycle(0);
    bit_cycle(1);
    repeat (W + 2) bit_cycle(0);
    got = grab(k + 1);
    chk(got == 8'h96, "R7 frame undisturbed", got, 8'h96);
    chk(serr_flag == 1, "R7 sync error flag", serr_flag, 1);
    chk(undf_flag == 0, "R7 no frame started by early sync", undf_flag, 0);
    chk(serr_legacy == 1, "R10 legacy set", serr_legacy, 1);
    chk(irq_n == 1, "R9 disabled sync error keeps irq high", irq_n, 1);
    chk(int_cnt == 1, "R11 one request in mode 3", int_cnt, 1);
    @(negedge clk); ien_serr = 1; @(negedge clk);
    chk(irq_n == 0, "R9 enabled sync error", irq_n, 0);
    clear_flags(2'b01);
    chk(serr_flag == 1, "R8 sync error kept by other mask", serr_flag, 1);
    clear_flags(2'b10);
    chk(serr_flag == 0 && irq_n == 1, "R8 sync error cleared", {serr_flag, irq_n}, 1);
    chk(serr_legacy == 1, "R10 legacy ignores write-one clear", serr_legacy, 1);
    @(negedge clk); leg_clr = 1; @(negedge clk); leg_clr = 0; @(negedge clk);
    chk(serr_legacy == 0, "R10 legacy cleared by strobe", serr_legacy, 0);

    // R12 earliest legal sync with delay two
    do_reset();
    write_word(8'hC3);
    write_word(8'h5A);
    dly_sel = 2'd2;
    k = ncyc; bit_cycle(1);
    repeat (W - 1) bit_cycle(0);
    bit_cycle(1);
    repeat (W + 3) bit_cycle(0);
    got = grab(k + 3);
    chk(got == 8'hC3, "R12 first frame", got, 8'hC3);
    got = grab(k + W + 3);
    chk(got == 8'h5A, "R12 back to back frame", got, 8'h5A);
    chk(serr_flag == 0 && undf_flag == 0, "R12 boundary sync accepted", {serr_flag, undf_flag}, 0);

    // R12 one period too early, R11 no request outside mode 3
    do_reset();
    int_mode = 2'b01;
    write_word(8'h81);
    dly_sel = 2'd2;
    k = ncyc; bit_cycle(1);
    repeat (W - 2) bit_cycle(0);
    bit_cycle(1);
    repeat (W + 3) bit_cycle(0);
    got = grab(k + 3);
    chk(got == 8'h81, "R12 frame survives early sync", got, 8'h81);
    chk(serr_flag == 1, "R12 early sync flagged", serr_flag, 1);
    chk(undf_flag == 0, "R12 early sync starts nothing", undf_flag, 0);
    chk(int_cnt == 0, "R11 no request in mode 1", int_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule